// File: doc/BRIEF.md
# Prescaled Pulse Width Modulator with Boundary-Latched Settings

This block produces a single pulse-width-modulated output from three settings: a period length, a duty length with a force-high flag, and a prescale divider. The core clock is divided by a clock-enable prescaler, and every prescaled tick advances a period counter. The output is high for the first `duty` ticks of each period and low for the rest.

The settings are copied into shadow registers only at the boundary between two periods. A setting changed in the middle of a period therefore never produces a partial or glitched period. Each period runs with one consistent set of values.

Degenerate settings give a fixed level: a zero period holds the output high, except when duty and the force flag are both zero. A duty longer than the period saturates to a constant high. A pulse output marks the first cycle of every period, so the caller can time its updates. Dropping the enable stops the block and returns the shadows to their defaults.

Top module: `pwm_cycle_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pwm_o` and `period_start_o` are 0.
- R2: One period lasts (period + 1) × (prescale + 1) core cycles. Consecutive `period_start_o` pulses are exactly that many cycles apart.
- R3: With the force flag clear and 0 < duty ≤ period, `pwm_o` is high for duty × (prescale + 1) core cycles at the start of each period and low for the rest. With duty = 0 and the flag clear, `pwm_o` is low for the whole period.
- R4: With the force flag set, `pwm_o` is high for the whole period, whatever the duty value.
- R5: A duty value of period + 1 or more gives an output that is high for the whole period.
- R6: With period = 0, each period lasts prescale + 1 cycles. The output is constantly high, unless the force flag and the duty are both 0; in that case it is constantly low.
- R7: The prescale field (6 bits) stretches every count step to prescale + 1 core cycles. A value of 0 means every core cycle is a step.
- R8: The settings are captured only on the clock edge that ends a period. A change during a period has no effect on that period. Settings that are stable for at least 4 core cycles before the end of a period govern the next period.
- R9: `period_start_o` is high for one core cycle, the first cycle of each new period, each time the shadows are loaded.
- R10: While `en` is low, `pwm_o` goes to 0 within one cycle, `period_start_o` stays 0, and the shadows return to their defaults (period 4, duty 0, flag 0, prescale 0). After `en` rises, the first period therefore lasts 5 core cycles with a low output. The next period uses the input settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle |
| period_i | input | 10 | Period setting, in prescaled steps (length is value + 1) |
| duty_i | input | 10 | Number of high steps at the start of each period |
| full_i | input | 1 | Force the output high for the whole period |
| prescale_i | input | 6 | Step stretch; each step is value + 1 core cycles |
| pwm_o | output | 1 | Registered modulated output |
| period_start_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
A settings write and a shadow load can fall in the same period. The bench drives that collision in two ways. It writes new values two cycles into a period, and it writes them exactly four cycles before the closing edge. It judges the outcome by counting high cycles and the distance between start pulses. The period in flight must keep the old duty and length, and the very next period must show the new ones. The same collision is also driven with a prescale change, which must not stretch the running period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    LVL_COMPARE = 2'd0,
    LVL_HIGH    = 2'd1,
    LVL_LOW     = 2'd2
  } lvl_sel_e;

  // Select how the output level is derived for the active shadow settings.
  function automatic lvl_sel_e pick_level(input logic force_hi,
                                          input logic per_zero,
                                          input logic duty_zero);
    if (force_hi)       return LVL_HIGH;
    else if (duty_zero) return LVL_LOW;
    else if (per_zero)  return LVL_HIGH;
    else                return LVL_COMPARE;
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int PS_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] div,
  output logic            tick
);

  logic [PS_W-1:0] pre_cnt;
  logic            at_end;

  assign at_end = (pre_cnt >= div);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
    end else if (at_end) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [PER_W-1:0] per,
  output logic [PER_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = tick && (cnt >= per);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (wrap) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int PER_W   = 10,
  parameter int DUTY_W  = 10,
  parameter int PS_W    = 6,
  parameter int PER_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load,
  input  logic [PER_W-1:0]  per_in,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              full_in,
  input  logic [PS_W-1:0]   ps_in,
  output logic [PER_W-1:0]  per_sh,
  output logic [DUTY_W-1:0] duty_sh,
  output logic              full_sh,
  output logic [PS_W-1:0]   ps_sh
);

  localparam logic [PER_W-1:0] PER_DEF = PER_W'(PER_RST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      per_sh  <= PER_DEF;
      duty_sh <= '0;
      full_sh <= 1'b0;
      ps_sh   <= '0;
    end else if (load) begin
      per_sh  <= per_in;
      duty_sh <= duty_in;
      full_sh <= full_in;
      ps_sh   <= ps_in;
    end
  end

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out
  import pwm_pkg::*;
#(
  parameter int PER_W  = 10,
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PER_W-1:0]  cnt,
  input  logic [PER_W-1:0]  per,
  input  logic [DUTY_W-1:0] duty,
  input  logic              force_hi,
  output logic              wave
);

  localparam int CW = (PER_W > DUTY_W) ? PER_W : DUTY_W;

  logic [CW-1:0] cnt_x;
  logic [CW-1:0] duty_x;
  lvl_sel_e      sel;
  logic          level_d;

  assign cnt_x  = CW'(cnt);
  assign duty_x = CW'(duty);
  assign sel    = pick_level(force_hi, (per == '0), (duty == '0));

  always_comb begin
    case (sel)
      LVL_HIGH:    level_d = 1'b1;
      LVL_LOW:     level_d = 1'b0;
      LVL_COMPARE: level_d = (cnt_x < duty_x);
      default:     level_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) wave <= 1'b0;
    else             wave <= level_d;
  end

endmodule

// File: rtl/pwm_cycle_gen.sv
module pwm_cycle_gen #(
  parameter int PER_W   = 10,
  parameter int DUTY_W  = 10,
  parameter int PS_W    = 6,
  parameter int PER_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PER_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              full_i,
  input  logic [PS_W-1:0]   prescale_i,
  output logic              pwm_o,
  output logic              period_start_o
);

  logic              tick;
  logic              wrap;
  logic [PER_W-1:0]  cnt;
  logic [PER_W-1:0]  per_sh;
  logic [DUTY_W-1:0] duty_sh;
  logic              full_sh;
  logic [PS_W-1:0]   ps_sh;

  pwm_prescale #(.PS_W(PS_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (en),
    .div  (ps_sh),
    .tick (tick)
  );

  pwm_period_cnt #(.PER_W(PER_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (en),
    .tick (tick),
    .per  (per_sh),
    .cnt  (cnt),
    .wrap (wrap)
  );

  pwm_shadow #(
    .PER_W  (PER_W),
    .DUTY_W (DUTY_W),
    .PS_W   (PS_W),
    .PER_RST(PER_RST)
  ) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .run     (en),
    .load    (wrap),
    .per_in  (period_i),
    .duty_in (duty_i),
    .full_in (full_i),
    .ps_in   (prescale_i),
    .per_sh  (per_sh),
    .duty_sh (duty_sh),
    .full_sh (full_sh),
    .ps_sh   (ps_sh)
  );

  pwm_wave_out #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .run      (en),
    .cnt      (cnt),
    .per      (per_sh),
    .duty     (duty_sh),
    .force_hi (full_sh),
    .wave     (pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) period_start_o <= 1'b0;
    else            period_start_o <= wrap;
  end

endmodule

// File: rtl/pwm_cycle_gen_chk.sv
module pwm_cycle_gen_chk #(
  parameter int PER_W  = 10,
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              pwm_o,
  input logic              period_start_o,
  input logic              load,
  input logic [PER_W-1:0]  cnt,
  input logic [PER_W-1:0]  per_sh,
  input logic [DUTY_W-1:0] duty_sh,
  input logic              full_sh
);

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o); // R10

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    period_start_o |-> (cnt == '0)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= per_sh)); // R2

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (en && full_sh) |=> pwm_o); // R4

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (en && !full_sh && (duty_sh == '0)) |=> !pwm_o); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> $stable(duty_sh)); // R8

endmodule

bind pwm_cycle_gen pwm_cycle_gen_chk #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .en             (en),
  .pwm_o          (pwm_o),
  .period_start_o (period_start_o),
  .load           (wrap),
  .cnt            (cnt),
  .per_sh         (per_sh),
  .duty_sh        (duty_sh),
  .full_sh        (full_sh)
);

// File: tb/pwm_cycle_gen_test.sv
module pwm_cycle_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [9:0] per_i  = '0;
  logic [9:0] duty_i = '0;
  logic       full_i = 1'b0;
  logic [5:0] ps_i   = '0;
  logic       pwm;
  logic       pstart;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  pwm_cycle_gen uut (
    .clk            (clk),
    .rst            (rst),
    .en             (en),
    .period_i       (per_i),
    .duty_i         (duty_i),
    .full_i         (full_i),
    .prescale_i     (ps_i),
    .pwm_o          (pwm),
    .period_start_o (pstart)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R2: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int p, input int d, input bit f, input int s);
    per_i  = p[9:0];
    duty_i = d[9:0];
    full_i = f;
    ps_i   = s[5:0];
  endtask

  // Samples one full period starting at a start-pulse negedge; optional write at step wr_at.
  task automatic run_period(input int exp_high, input int len, input string req,
                            input int wr_at = 0, input int np = 0, input int nd = 0,
                            input bit nf = 1'b0, input int ns = 0);
    int hi = 0;
    int bad_pulse = 0;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (pwm) hi++;
      if (i < len && pstart) bad_pulse++;
      if (i == len && !pstart) bad_pulse++;
      if (i == wr_at) set_cfg(np, nd, nf, ns);
    end
    check(hi == exp_high, {req, " high cycles"}, hi, exp_high);
    check(bad_pulse == 0, {req, " R2 R9 start pulse spacing"}, bad_pulse, 0);
  endtask

  // Raises enable and measures the default first period (R10).
  task automatic enable_and_measure(input string req);
    int n = 0;
    int hi = 0;
    @(negedge clk);
    en = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (pwm) hi++;
    end while (!pstart && n < 1000);
    check(n == 5, {req, " default period length"}, n, 5);
    check(hi == 0, {req, " default period low"}, hi, 0);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check(pwm == 1'b0 && pstart == 1'b0, "R1 in reset", {pwm, pstart}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm == 1'b0 && pstart == 1'b0, "R1 after reset", {pwm, pstart}, 0);
    repeat (3) @(negedge clk);
    check(pwm == 1'b0, "R10 idle while disabled", pwm, 0);
  endtask

  task automatic t_basic;
    set_cfg(10, 6, 1'b0, 0);
    enable_and_measure("R10");
    run_period(6, 11, "R3 basic");
    run_period(6, 11, "R2 basic repeat");
  endtask

  task automatic t_prescale;
    set_cfg(4, 2, 1'b0, 2);
    run_period(6, 11, "R8 old values kept");
    run_period(6, 15, "R7 prescale 2");
    run_period(6, 15, "R7 prescale 2 repeat");
  endtask

  task automatic t_full;
    set_cfg(7, 3, 1'b1, 0);
    run_period(6, 15, "R7 before force");
    run_period(8, 8, "R4 force high");
  endtask

  task automatic t_saturate;
    set_cfg(5, 9, 1'b0, 0);
    run_period(8, 8, "R4 before saturate");
    run_period(6, 6, "R5 duty above period");
    set_cfg(5, 6, 1'b0, 0);
    run_period(6, 6, "R5 before edge case");
    run_period(6, 6, "R5 duty equals period plus one");
  endtask

  task automatic t_zero_duty;
    set_cfg(6, 0, 1'b0, 0);
    run_period(6, 6, "R5 before zero duty");
    run_period(0, 7, "R3 zero duty low");
  endtask

  task automatic t_per_zero;
    set_cfg(0, 0, 1'b0, 0);
    run_period(0, 7, "R3 before zero period");
    for (int k = 0; k < 3; k++) run_period(0, 1, "R6 zero period all zero low");
    set_cfg(0, 3, 1'b0, 0);
    run_period(0, 1, "R6 transition");
    for (int k = 0; k < 3; k++) run_period(1, 1, "R6 zero period high");
    set_cfg(0, 0, 1'b1, 0);
    run_period(1, 1, "R6 transition force");
    for (int k = 0; k < 3; k++) run_period(1, 1, "R6 zero period forced high");
  endtask

  task automatic t_mid_write;
    set_cfg(9, 3, 1'b0, 0);
    run_period(1, 1, "R6 leaving zero period");
    run_period(3, 10, "R8 mid period write ignored", 2, 9, 8, 1'b0, 0);
    run_period(8, 10, "R8 write applied next period", 6, 4, 1, 1'b0, 0);
    run_period(1, 5, "R8 write four cycles before end", 1, 4, 1, 1'b0, 3);
    run_period(4, 20, "R7 prescale change applied at boundary");
  endtask

  task automatic t_disable;
    int bad = 0;
    @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pwm || pstart) bad++;
    end
    check(bad == 0, "R10 disabled outputs low", bad, 0);
    set_cfg(2, 1, 1'b0, 0);
    enable_and_measure("R10 re-enable");
    run_period(1, 3, "R10 inputs used after default period");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_prescale();
    t_full();
    t_saturate();
    t_zero_duty();
    t_per_zero();
    t_mid_write();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule